// File: doc/BRIEF.md
# Scanline Register Write Sequencer

This block sits inside a video controller and updates that controller's own register file while the beam moves. Software leaves a list in video memory and loads its start address into a base input. The list holds one record per scanline. Each record gives the horizontal cycle at which writing begins, then any number of register-number/value byte pairs, then a terminator. The record for a scanline is read in full during the scanline before it and held in a line buffer. When the beam reaches the record's start cycle, the held pairs are written one per cycle. Cycles on which character DMA owns the bus are skipped.

The list pointer is reloaded at every frame boundary. The first record of a frame is read during line 0 and drives line 1. Line 0 of each frame carries no writes. Two line buffers alternate: one is filled while the other is drained. A record whose first byte is the terminator ends the list for the rest of the frame. Two outputs report trouble. One is a sticky flag for records that were too long. The other is a count of pairs that were dropped because the line ran out of cycles.

Top module: `scanline_reglist_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises: `reg_we` = 0, `mem_rd` = 0, `overflow` = 0 and `missed_count` = 0. After reset the block makes no reads until the next frame boundary.
- R2: A frame boundary is the clock edge on which `beam_x` = LINE_CYC-1 and `beam_y` = FRAME_LINES-1. While enabled, the first read after that edge is issued in cycle (line 0, x 0) at address `list_base`, and this happens in every frame.
- R3: A record is a start byte, then pairs of (register byte, value byte), then 0xFF in place of a register byte. A value byte of 0xFF is data. The record read during line N is written during line N+1, and line 0 has no writes.
- R4: Writes begin on the first cycle whose `beam_x` is at least the record's start byte. After that, one pair goes out per free cycle, in list order, with `reg_addr`/`reg_wdata` valid in the same cycle as `reg_we`.
- R5: No write is issued in a cycle where `bad_cycle` = 1. The pending pair moves to the next cycle that is not blocked.
- R6: A record whose first byte is 0xFF ends the list. No further reads or writes happen until the next frame boundary.
- R7: A record may hold more than MAX_PAIRS (16) pairs. Only its first 16 are written, the rest are read and skipped, and `overflow` rises to 1 and stays at 1 until reset.
- R8: Pairs still unwritten when the line's last cycle ends are dropped. Their number is added to `missed_count`, which saturates at its all-ones value.
- R9: The target register is the low 6 bits of the register byte. A number above MAX_REG (46) uses up its cycle but produces no `reg_we`.
- R10: While `enable` = 0, `mem_rd` and `reg_we` stay 0. After `enable` returns to 1, nothing happens until the next frame boundary.
- R11: Read data arrives on `mem_rdata` one cycle after `mem_rd`. A record is read at consecutive addresses with no read past its terminator, and the next record starts at the following address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per beam position |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Sequencer on |
| list_base | input | ADDR_W | Start address of the list, loaded at frame boundaries |
| beam_x | input | clog2(LINE_CYC) | Horizontal cycle within the line |
| beam_y | input | clog2(FRAME_LINES) | Line within the frame |
| bad_cycle | input | 1 | Character DMA owns this cycle |
| mem_rd | output | 1 | Video memory read request |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| reg_we | output | 1 | Register file write strobe |
| reg_addr | output | 6 | Register number |
| reg_wdata | output | 8 | Register value |
| overflow | output | 1 | Sticky: a record exceeded the line buffer |
| missed_count | output | MISS_W | Saturating count of dropped pairs |

## Verification
The assertions assume that the beam inputs count in order through each line and frame, and that `mem_rdata` is valid in the cycle after each read request. The bench drives the beam from a free-running counter and feeds reads from a registered byte array, so both assumptions hold throughout. Blocked cycles come from a fixed map of beam positions chosen to land inside write bursts. The list length is chosen so that every record finishes reading well before the end of its line.

// File: rtl/rl_pkg.sv
package rl_pkg;
   typedef enum logic [1:0] {
      PH_START,
      PH_REG,
      PH_VAL
   } rec_phase_e;

   localparam logic [7:0] REC_END = 8'hFF;
endpackage

// File: rtl/rl_fetch.sv
module rl_fetch
   import rl_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int MAX_PAIRS = 16,
   parameter int REG_AW    = 6,
   parameter int CNT_W     = $clog2(MAX_PAIRS + 1),
   parameter int IDX_W     = $clog2(MAX_PAIRS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              frame_edge,
   input  logic              line_edge,
   input  logic [ADDR_W-1:0] list_base,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [REG_AW-1:0] wr_reg,
   output logic [7:0]        wr_val,
   output logic              rec_ok,
   output logic [CNT_W-1:0]  rec_cnt,
   output logic [7:0]        rec_hstart,
   output logic              overflow
);
   rec_phase_e        ph;
   logic              running, list_end, inflight;
   logic [CNT_W-1:0]  npairs;
   logic [7:0]        hstart;
   logic [REG_AW-1:0] cur_reg;
   logic [ADDR_W-1:0] fptr;
   logic              is_end, start_rec, room;

   // terminator seen on returning data: stop reading this very cycle
   assign is_end    = inflight && (mem_rdata == REC_END) && (ph != PH_VAL);
   assign mem_rd    = en && running && !is_end;
   assign mem_addr  = fptr;
   assign room      = npairs < CNT_W'(MAX_PAIRS);
   assign wr_en     = inflight && (ph == PH_VAL) && room;
   assign wr_idx    = npairs[IDX_W-1:0];
   assign wr_reg    = cur_reg;
   assign wr_val    = mem_rdata;
   assign start_rec = en && (frame_edge || (line_edge && rec_ok && !list_end));
   assign rec_cnt   = npairs;
   assign rec_hstart = hstart;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running  <= 1'b0;
         list_end <= 1'b1;
         inflight <= 1'b0;
         ph       <= PH_START;
         npairs   <= '0;
         hstart   <= '0;
         cur_reg  <= '0;
         fptr     <= '0;
         rec_ok   <= 1'b0;
         overflow <= 1'b0;
      end else if (!en) begin
         running  <= 1'b0;
         list_end <= 1'b1;
         inflight <= 1'b0;
         rec_ok   <= 1'b0;
      end else begin
         inflight <= mem_rd;
         if (mem_rd) fptr <= fptr + 1'b1;
         if (inflight) begin
            case (ph)
               PH_START: begin
                  if (is_end) begin
                     running  <= 1'b0;
                     list_end <= 1'b1;
                  end else begin
                     hstart <= mem_rdata;
                     ph     <= PH_REG;
                  end
               end
               PH_REG: begin
                  if (is_end) begin
                     running <= 1'b0;
                     rec_ok  <= 1'b1;
                  end else begin
                     cur_reg <= mem_rdata[REG_AW-1:0];
                     ph      <= PH_VAL;
                  end
               end
               PH_VAL: begin
                  if (room) npairs <= npairs + 1'b1;
                  else      overflow <= 1'b1;
                  ph <= PH_REG;
               end
               default: ph <= PH_START;
            endcase
         end
         if (start_rec) begin
            running  <= 1'b1;
            inflight <= 1'b0;
            ph       <= PH_START;
            npairs   <= '0;
            rec_ok   <= 1'b0;
            if (frame_edge) begin
               list_end <= 1'b0;
               fptr     <= list_base;
            end
         end
      end
   end

   p_no_fetch_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !mem_rd);
   p_end_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      list_end |-> !mem_rd);
   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);
   p_pairs_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      npairs <= CNT_W'(MAX_PAIRS));
   p_seq_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !frame_edge) |=> (!mem_rd || mem_addr == $past(mem_addr) + 1'b1));
endmodule

// File: rtl/rl_pairbuf.sv
module rl_pairbuf #(
   parameter int DEPTH  = 16,
   parameter int REG_AW = 6,
   parameter int IDX_W  = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [REG_AW-1:0] wr_reg,
   input  logic [7:0]        wr_val,
   input  logic              rd_bank,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [REG_AW-1:0] rd_reg,
   output logic [7:0]        rd_val
);
   localparam int BANKS = 2;

   logic [REG_AW-1:0] bank_reg [BANKS];
   logic [7:0]        bank_val [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [REG_AW-1:0] reg_mem [DEPTH];
      logic [7:0]        val_mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == 1'(b))) begin
            reg_mem[wr_idx] <= wr_reg;
            val_mem[wr_idx] <= wr_val;
         end
      end
      assign bank_reg[b] = reg_mem[rd_idx];
      assign bank_val[b] = val_mem[rd_idx];
   end

   assign rd_reg = bank_reg[rd_bank];
   assign rd_val = bank_val[rd_bank];
endmodule

// File: rtl/rl_issue.sv
module rl_issue #(
   parameter int XW        = 6,
   parameter int MAX_PAIRS = 16,
   parameter int REG_AW    = 6,
   parameter int MAX_REG   = 46,
   parameter int MISS_W    = 8,
   parameter int CNT_W     = $clog2(MAX_PAIRS + 1),
   parameter int IDX_W     = $clog2(MAX_PAIRS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              line_edge,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic [7:0]        load_hstart,
   input  logic [XW-1:0]     beam_x,
   input  logic              bad_cycle,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic [REG_AW-1:0] rd_reg,
   input  logic [7:0]        rd_val,
   output logic              reg_we,
   output logic [REG_AW-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   output logic [MISS_W-1:0] missed_count
);
   logic [CNT_W-1:0]  cnt, idx, left;
   logic [7:0]        hstart;
   logic              slot;
   logic [MISS_W:0]   sum;

   assign slot      = en && (idx < cnt) && (8'(beam_x) >= hstart) && !bad_cycle;
   assign reg_we    = slot && (rd_reg <= REG_AW'(MAX_REG));
   assign reg_addr  = rd_reg;
   assign reg_wdata = rd_val;
   assign rd_idx    = idx[IDX_W-1:0];
   assign left      = cnt - idx - CNT_W'(slot);
   assign sum       = {1'b0, missed_count} + (MISS_W+1)'(left);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt          <= '0;
         idx          <= '0;
         hstart       <= '0;
         missed_count <= '0;
      end else if (!en) begin
         cnt <= '0;
         idx <= '0;
      end else if (line_edge) begin
         missed_count <= sum[MISS_W] ? '1 : sum[MISS_W-1:0];
         idx          <= '0;
         if (load) begin
            cnt    <= load_cnt;
            hstart <= load_hstart;
         end else begin
            cnt <= '0;
         end
      end else if (slot) begin
         idx <= idx + 1'b1;
      end
   end

   p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= cnt);
   p_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (slot && !line_edge) |=> idx == $past(idx) + 1'b1);
   p_missed_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> missed_count >= $past(missed_count));
   p_no_bad_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !bad_cycle);
endmodule

// File: rtl/scanline_reglist_seq.sv
module scanline_reglist_seq #(
   parameter int ADDR_W      = 16,
   parameter int LINE_CYC    = 63,
   parameter int FRAME_LINES = 312,
   parameter int MAX_PAIRS   = 16,
   parameter int REG_AW      = 6,
   parameter int MAX_REG     = 46,
   parameter int MISS_W      = 8,
   localparam int XW         = $clog2(LINE_CYC),
   localparam int YW         = $clog2(FRAME_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [ADDR_W-1:0] list_base,
   input  logic [XW-1:0]     beam_x,
   input  logic [YW-1:0]     beam_y,
   input  logic              bad_cycle,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rdata,
   output logic              reg_we,
   output logic [REG_AW-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   output logic              overflow,
   output logic [MISS_W-1:0] missed_count
);
   localparam int CNT_W = $clog2(MAX_PAIRS + 1);
   localparam int IDX_W = $clog2(MAX_PAIRS);

   if (LINE_CYC > 256)            begin : g_bad_line  $error("LINE_CYC must fit the 8-bit start byte"); end
   if (MAX_PAIRS < 2)             begin : g_bad_depth $error("MAX_PAIRS must be at least 2"); end
   if (MAX_REG >= (1 << REG_AW))  begin : g_bad_reg   $error("MAX_REG exceeds register number width"); end
   if (MISS_W < CNT_W)            begin : g_bad_miss  $error("MISS_W narrower than pair count"); end

   logic              line_edge, frame_edge, load, wr_bank;
   logic              f_wr_en, f_rec_ok;
   logic [IDX_W-1:0]  f_wr_idx, i_rd_idx;
   logic [REG_AW-1:0] f_wr_reg, b_rd_reg;
   logic [7:0]        f_wr_val, b_rd_val, f_hstart;
   logic [CNT_W-1:0]  f_cnt;

   assign line_edge  = beam_x == XW'(LINE_CYC - 1);
   assign frame_edge = line_edge && (beam_y == YW'(FRAME_LINES - 1));
   assign load       = enable && line_edge && f_rec_ok && !frame_edge;

   always_ff @(posedge clk) begin
      if (!rst_n)    wr_bank <= 1'b0;
      else if (load) wr_bank <= ~wr_bank;
   end

   rl_fetch #(.ADDR_W(ADDR_W), .MAX_PAIRS(MAX_PAIRS), .REG_AW(REG_AW)) u_fetch (
      .clk(clk), .rst_n(rst_n), .en(enable), .frame_edge(frame_edge),
      .line_edge(line_edge), .list_base(list_base), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .wr_en(f_wr_en),
      .wr_idx(f_wr_idx), .wr_reg(f_wr_reg), .wr_val(f_wr_val),
      .rec_ok(f_rec_ok), .rec_cnt(f_cnt), .rec_hstart(f_hstart),
      .overflow(overflow)
   );

   rl_pairbuf #(.DEPTH(MAX_PAIRS), .REG_AW(REG_AW)) u_buf (
      .clk(clk), .wr_en(f_wr_en), .wr_bank(wr_bank), .wr_idx(f_wr_idx),
      .wr_reg(f_wr_reg), .wr_val(f_wr_val), .rd_bank(~wr_bank),
      .rd_idx(i_rd_idx), .rd_reg(b_rd_reg), .rd_val(b_rd_val)
   );

   rl_issue #(.XW(XW), .MAX_PAIRS(MAX_PAIRS), .REG_AW(REG_AW), .MAX_REG(MAX_REG),
              .MISS_W(MISS_W)) u_issue (
      .clk(clk), .rst_n(rst_n), .en(enable), .line_edge(line_edge),
      .load(load), .load_cnt(f_cnt), .load_hstart(f_hstart),
      .beam_x(beam_x), .bad_cycle(bad_cycle), .rd_idx(i_rd_idx),
      .rd_reg(b_rd_reg), .rd_val(b_rd_val), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .missed_count(missed_count)
   );

   p_write_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !reg_we);
   p_reg_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> reg_addr <= REG_AW'(MAX_REG));
   p_idle_line0_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_edge |=> !reg_we);
endmodule

// File: tb/scanline_reglist_seq_bench.sv
module scanline_reglist_seq_bench;
   localparam int LINES  = 6;
   localparam int LCYC   = 63;
   localparam int XW     = $clog2(LCYC);
   localparam int YW     = $clog2(LINES);
   localparam int NEXP   = 24;
   localparam logic [15:0] BASE = 16'd64;

   // {line, x, register, value}
   localparam logic [31:0] EXP [NEXP] = '{
      32'h010A01A1, 32'h010D02A2, 32'h010E03A3,
      32'h023C04B1, 32'h023D05B2, 32'h023E06B3,
      32'h030005C1, 32'h03022EC3,
      32'h040510D0, 32'h040611D1, 32'h040812D2, 32'h040913D3,
      32'h040A14D4, 32'h040B15D5, 32'h040C16D6, 32'h040D17D7,
      32'h040E18D8, 32'h040F19D9, 32'h04101ADA, 32'h04111BDB,
      32'h04121CDC, 32'h04131DDD, 32'h04141EDE, 32'h04151FDF
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b1;
   logic [15:0] list_base = BASE;
   logic [XW-1:0] bx = '0;
   logic [YW-1:0] by = YW'(LINES - 1);
   logic bad_cycle;
   logic mem_rd, reg_we, overflow;
   logic [15:0] mem_addr;
   logic [7:0] mem_rdata, reg_wdata, missed_count;
   logic [5:0] reg_addr;
   logic [7:0] mem [256];

   int n_tests = 0, n_fail = 0;
   int nw = 0, nr = 0, rd_bad = 0, rd_origin = 0;
   logic [15:0] prev_ra = '0;
   logic [31:0] wlog [128];
   bit done = 0;

   always #5 clk = ~clk;

   scanline_reglist_seq #(.FRAME_LINES(LINES), .LINE_CYC(LCYC)) u_scanline_reglist_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable), .list_base(list_base),
      .beam_x(bx), .beam_y(by), .bad_cycle(bad_cycle), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .overflow(overflow),
      .missed_count(missed_count)
   );

   assign bad_cycle = (by == 1 && (bx == 11 || bx == 12)) || (by == 4 && bx == 7);

   always @(posedge clk) begin
      if (bx == XW'(LCYC - 1)) begin
         bx <= '0;
         by <= (by == YW'(LINES - 1)) ? '0 : by + 1'b1;
      end else begin
         bx <= bx + 1'b1;
      end
      if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
   end

   always @(negedge clk) begin
      if (reg_we) begin
         if (nw < 128) wlog[nw] = {8'(by), 8'(bx), 2'b00, reg_addr, reg_wdata};
         nw++;
      end
      if (mem_rd) begin
         if (by == 0 && bx == 0) begin
            rd_origin++;
            if (mem_addr !== list_base) rd_bad++;
         end else if (mem_addr !== prev_ra + 16'd1) begin
            rd_bad++;
         end
         prev_ra = mem_addr;
         nr++;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic wait_pos(input int y, input int x);
      do step(); while (!(int'(by) == y && int'(bx) == x));
   endtask

   task automatic walk_table(input int base_idx, input string tag);
      for (int i = 0; i < NEXP; i++) begin
         string req;
         case (EXP[i][31:24])
            8'd1:    req = {tag, " R5"};
            8'd2:    req = {tag, " R8"};
            8'd3:    req = {tag, " R9"};
            default: req = {tag, " R7"};
         endcase
         chk(req, wlog[base_idx + i], EXP[i]);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      int p = int'(BASE);
      int w0, r0, r_l5;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      // line 1 record
      mem[p++] = 8'd10;
      for (int i = 0; i < 3; i++) begin mem[p++] = 8'(i + 1); mem[p++] = 8'(8'hA1 + i); end
      mem[p++] = 8'hFF;
      // line 2 record: too late to finish
      mem[p++] = 8'd60;
      for (int i = 0; i < 5; i++) begin mem[p++] = 8'(i + 4); mem[p++] = 8'(8'hB1 + i); end
      mem[p++] = 8'hFF;
      // line 3 record: masked number and out-of-range register
      mem[p++] = 8'd0;
      mem[p++] = 8'h45; mem[p++] = 8'hC1;
      mem[p++] = 8'h30; mem[p++] = 8'hC2;
      mem[p++] = 8'h2E; mem[p++] = 8'hC3;
      mem[p++] = 8'hFF;
      // line 4 record: 18 pairs
      mem[p++] = 8'd5;
      for (int i = 0; i < 18; i++) begin mem[p++] = 8'(8'h10 + i); mem[p++] = 8'(8'hD0 + i); end
      mem[p++] = 8'hFF;
      // end of list
      mem[p++] = 8'hFF;

      repeat (3) step();
      chk("R1 reg_we", 32'(reg_we), 0);
      chk("R1 mem_rd", 32'(mem_rd), 0);
      chk("R1 overflow", 32'(overflow), 0);
      chk("R1 missed", 32'(missed_count), 0);
      rst_n = 1'b1;
      step();
      chk("R1 reg_we after release", 32'(reg_we), 0);

      // frame 1
      wait_pos(0, 0);
      chk("R1 no read before frame boundary", 32'(nr), 0);
      w0 = nw; r0 = nr;
      wait_pos(3, 0);
      chk("R8 missed after line 2", 32'(missed_count), 2);
      chk("R7 overflow clear before long record", 32'(overflow), 0);
      wait_pos(5, 0);
      chk("R7 overflow set", 32'(overflow), 1);
      r_l5 = nr;
      wait_pos(0, 0);
      chk("R4 write count frame 1", 32'(nw - w0), NEXP);
      chk("R3 first write on line 1", 32'(wlog[w0][31:24]), 1);
      walk_table(w0, "frame1");
      chk("R11 read count", 32'(nr - r0), 67);
      chk("R6 no reads after list end", 32'(nr - r_l5), 0);
      chk("R11 consecutive addresses", 32'(rd_bad), 0);
      chk("R2 read at line 0 cycle 0", 32'(rd_origin), 1);

      // frame 2: disable during line 1, re-enable during line 3
      w0 = nw; r0 = nr;
      wait_pos(1, 0);
      enable = 1'b0;
      step();
      chk("R10 mem_rd low while off", 32'(mem_rd), 0);
      wait_pos(3, 0);
      enable = 1'b1;
      wait_pos(0, 0);
      chk("R10 no writes in disabled frame", 32'(nw - w0), 0);
      chk("R10 only line 0 read before disable", 32'(nr - r0), 8);
      chk("R8 missed unchanged while off", 32'(missed_count), 2);

      // frame 3: pointer reloaded from base
      w0 = nw; r0 = nr;
      wait_pos(0, 0);
      chk("R2 write count after reload", 32'(nw - w0), NEXP);
      walk_table(w0, "frame3 R2");
      chk("R2 base address each frame", 32'(rd_bad), 0);
      chk("R2 origin reads", 32'(rd_origin), 3);
      chk("R8 missed accumulates", 32'(missed_count), 4);
      chk("R7 overflow sticky", 32'(overflow), 1);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end
endmodule